// File: doc/BRIEF.md
# Serial ADC Read Sequencer

This block is the host-side master for a 12-bit successive-approximation converter that has a three-wire serial port: an active-low select, a clock and a data line. On a start request it pulls the select line low while holding the serial clock low, which makes the converter sample and begin converting. It then waits for the converter to report that the conversion is complete. Completion is seen either as a rising edge on the data line or as the expiry of the maximum conversion time, whichever happens first.

After completion the block produces the serial clock from a programmable divider of the system clock, with clock polarity and phase both 0, and samples the data line on every rising edge. The first bit it captures is a framing bit that should read 1. Twelve result bits follow, most significant first. In continuous mode 13 clocks are issued. In byte mode 16 clocks are issued as two back-to-back 8-clock transfers, and the three trailing bits are dropped. At the end of a read the block raises select, presents the result with a framing-error flag and pulses a done output.

The block also enforces the minimum select-high time between reads and a longer acquisition gap after an aborted read. A hold-off counter keeps start requests blocked for a settling interval after reset and after a shutdown is released. All timing limits are given in nanoseconds and converted to system-clock cycles from a clock frequency parameter.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0 and `done` is 0. No start is accepted until HOLDOFF_CYC system cycles after reset is released.
- R2: A start request made while idle drives `cs_n` low with `sclk` low. `sclk` stays low for the whole conversion wait and toggles only while the read is clocking data.
- R3: If `sdo_in` rises during the conversion wait, clocking begins after a short synchronizer delay, well before the conversion timeout.
- R4: If `sdo_in` never rises, the first `sclk` rising edge comes CONV_CYC + HALF_DIV + 1 cycles after `cs_n` falls. CONV_CYC is T_CONV_NS converted to cycles and rounded up.
- R5: Each `sclk` high phase and each low phase between edges lasts exactly HALF_DIV system cycles. Elaboration fails if HALF_DIV is shorter than T_MINPH_NS.
- R6: With `byte_mode`=0, a read issues exactly 13 `sclk` rising edges. Sample 1 is the framing bit and samples 2 to 13 are result bits 11 down to 0.
- R7: With `byte_mode`=1, a read issues exactly 16 rising edges. Samples 2 to 13 form the result, and samples 14 to 16 have no effect on `result` or `frame_err`, even when they are 1.
- R8: `cs_n` rises on the same system clock edge as the final `sclk` falling edge. In the cycle that follows, `done` is 1 for exactly one cycle and `result` and `frame_err` are valid, and they stay valid until the next done.
- R9: `frame_err` is 1 exactly when the first sample of the read was 0. `result` still carries samples 2 to 13.
- R10: After a completed read, `cs_n` stays high for at least CSH_CYC cycles (T_CSH_NS converted to cycles) before the next start.
- R11: An `abort_req` during the conversion wait or during clocking raises `cs_n` and forces `sclk` low on the next edge. No done is produced, and the next start is held off for at least ACQ_CYC cycles (T_ACQ_NS converted to cycles).
- R12: While `pwr_down` is 1, a read in progress is aborted and every start is refused. After `pwr_down` returns to 0, starts stay blocked for HOLDOFF_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to start a read; taken only when idle and the gaps have elapsed |
| byte_mode | input | 1 | 0: 13-clock continuous read, 1: two 8-clock transfers; latched at start |
| abort_req | input | 1 | Cancels a read in progress |
| pwr_down | input | 1 | Converter is shut down; aborts, blocks starts, restarts hold-off |
| cs_n | output | 1 | Active-low select to the converter |
| sclk | output | 1 | Serial clock to the converter, idle low |
| sdo_in | input | 1 | Serial data and end-of-conversion flag from the converter |
| done | output | 1 | One-cycle pulse when a read completes |
| result | output | 12 | Conversion result |
| frame_err | output | 1 | Framing bit read as 0 |

## Verification
The bench builds the block at 125 MHz with HALF_DIV=13. That is the smallest divider that meets the 100 ns phase minimum at this clock, so the elaboration check is exercised right at its limit. The real nanosecond limits are kept, so the 1063-cycle conversion timeout, the 63-cycle select-high gap and the 188-cycle acquisition gap are all measured at their true lengths. HOLDOFF_CYC is reduced to 300, which brings both the post-reset hold-off and the post-shutdown hold-off inside a short run.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int CODE_W   = 12;
    localparam int CLK_CONT = 13;
    localparam int CLK_BYTE = 16;
    localparam int SH_W     = CLK_BYTE;
    localparam int NCLK_W   = $clog2(CLK_BYTE + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_SHIFT,
        ST_GAP
    } rd_state_e;

    typedef struct packed {
        logic              ferr;
        logic [CODE_W-1:0] code;
    } rd_word_t;

    // Round a nanosecond interval up to whole system cycles.
    function automatic int ns_to_cyc(input int ns, input int khz);
        longint prod;
        prod = longint'(ns) * longint'(khz);
        return int'((prod + 64'd999999) / 64'd1000000);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              stop,
    input  logic [NCLK_W-1:0] nclk,
    output logic              sclk,
    output logic              smp,
    output logic              fin
);
    localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(HALF_DIV - 1);

    logic              run;
    logic [PW-1:0]     ph;
    logic [NCLK_W-1:0] falls;
    logic              tick;

    assign tick = run && (ph == PH_LAST);
    assign smp  = tick && !sclk;
    assign fin  = tick && sclk && (falls == nclk - NCLK_W'(1));

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            run   <= 1'b0;
            ph    <= '0;
            falls <= '0;
            sclk  <= 1'b0;
        end else if (go) begin
            run   <= 1'b1;
            ph    <= '0;
            falls <= '0;
            sclk  <= 1'b0;
        end else if (run) begin
            if (tick) begin
                ph   <= '0;
                sclk <= ~sclk;
                if (sclk)
                    falls <= falls + 1'b1;
                if (fin)
                    run <= 1'b0;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift
    import adc_rd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     smp,
    input  logic     sdo,
    input  logic     byte_mode,
    output rd_word_t word
);
    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (smp)
            sh <= {sh[SH_W-2:0], sdo};
    end

    // The framing bit sits one place above the result; tail bits sit below it.
    always_comb begin
        if (byte_mode) begin
            word.ferr = ~sh[CLK_BYTE-1];
            word.code = sh[CLK_BYTE-2 -: CODE_W];
        end else begin
            word.ferr = ~sh[CLK_CONT-1];
            word.code = sh[CLK_CONT-2 -: CODE_W];
        end
    end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int SYS_FREQ_KHZ = 125000,
    parameter int HALF_DIV     = 13,
    parameter int T_CONV_NS    = 8500,
    parameter int T_CSH_NS     = 500,
    parameter int T_ACQ_NS     = 1500,
    parameter int T_MINPH_NS   = 100,
    parameter int HOLDOFF_CYC  = 2500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              byte_mode,
    input  logic              abort_req,
    input  logic              pwr_down,
    output logic              cs_n,
    output logic              sclk,
    input  logic              sdo_in,
    output logic              done,
    output logic [CODE_W-1:0] result,
    output logic              frame_err
);
    localparam int CONV_CYC  = ns_to_cyc(T_CONV_NS, SYS_FREQ_KHZ);
    localparam int CSH_CYC   = ns_to_cyc(T_CSH_NS, SYS_FREQ_KHZ);
    localparam int ACQ_CYC   = imax(ns_to_cyc(T_ACQ_NS, SYS_FREQ_KHZ), CSH_CYC);
    localparam int MINPH_CYC = ns_to_cyc(T_MINPH_NS, SYS_FREQ_KHZ);
    localparam int TMAX      = imax(imax(CONV_CYC, ACQ_CYC), HOLDOFF_CYC);
    localparam int TW        = $clog2(TMAX + 1);

    generate
        if (HALF_DIV < MINPH_CYC || HALF_DIV < 1) begin : g_div_check
            $error("HALF_DIV shorter than the minimum serial clock phase");
        end
    endgenerate

    rd_state_e state;
    logic      cs_n_q, done_q, mode_q;
    rd_word_t  res_q, word;
    logic [2:0] sdo_s;
    logic      eoc_rise, conv_exp, gap_exp, hold_exp;
    logic      busy, kill, start_ok, go, fin, smp, sclk_w;
    logic      gap_load;
    logic [TW-1:0]     gap_val;
    logic [NCLK_W-1:0] nclk;

    // End-of-conversion edge: two-stage synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (rst) sdo_s <= '0;
        else     sdo_s <= {sdo_s[1:0], sdo_in};
    end
    assign eoc_rise = sdo_s[1] && !sdo_s[2];

    assign busy     = (state == ST_CONV) || (state == ST_SHIFT);
    assign kill     = busy && (abort_req || pwr_down);
    assign start_ok = (state == ST_IDLE) && start_req && hold_exp
                      && !pwr_down && !abort_req;
    assign go       = (state == ST_CONV) && !kill && (eoc_rise || conv_exp);
    assign gap_load = kill || ((state == ST_SHIFT) && fin);
    assign gap_val  = kill ? TW'(ACQ_CYC) : TW'(CSH_CYC);
    assign nclk     = mode_q ? NCLK_W'(CLK_BYTE) : NCLK_W'(CLK_CONT);

    adc_rd_timer #(.W(TW), .RST_VAL(0)) u_conv_tmr (
        .clk(clk), .rst(rst), .load(start_ok), .val(TW'(CONV_CYC)),
        .expired(conv_exp)
    );

    adc_rd_timer #(.W(TW), .RST_VAL(0)) u_gap_tmr (
        .clk(clk), .rst(rst), .load(gap_load), .val(gap_val),
        .expired(gap_exp)
    );

    adc_rd_timer #(.W(TW), .RST_VAL(HOLDOFF_CYC)) u_hold_tmr (
        .clk(clk), .rst(rst), .load(pwr_down), .val(TW'(HOLDOFF_CYC)),
        .expired(hold_exp)
    );

    adc_rd_sclk #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk(clk), .rst(rst), .go(go), .stop(kill), .nclk(nclk),
        .sclk(sclk_w), .smp(smp), .fin(fin)
    );

    adc_rd_shift u_shift (
        .clk(clk), .rst(rst), .smp(smp), .sdo(sdo_in),
        .byte_mode(mode_q), .word(word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
            mode_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state  <= ST_CONV;
                        cs_n_q <= 1'b0;
                        mode_q <= byte_mode;
                    end
                end
                ST_CONV: begin
                    if (kill) begin
                        state  <= ST_GAP;
                        cs_n_q <= 1'b1;
                    end else if (go) begin
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (kill) begin
                        state  <= ST_GAP;
                        cs_n_q <= 1'b1;
                    end else if (fin) begin
                        state  <= ST_GAP;
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        res_q  <= word;
                    end
                end
                default: begin
                    if (gap_exp)
                        state <= ST_IDLE;
                end
            endcase
        end
    end

    assign cs_n      = cs_n_q;
    assign sclk      = sclk_w;
    assign done      = done_q;
    assign result    = res_q.code;
    assign frame_err = res_q.ferr;

    // Observation counters for the timing properties below.
    logic sclk_d, ab_flag;
    int   hold_cnt, csh_cnt, rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            hold_cnt <= HALF_DIV;
            csh_cnt  <= TMAX + 1;
            ab_flag  <= 1'b0;
            rise_cnt <= 0;
        end else begin
            sclk_d   <= sclk_w;
            hold_cnt <= (sclk_w != sclk_d) ? 1 : hold_cnt + 1;
            if (!cs_n_q)             csh_cnt <= 0;
            else if (csh_cnt <= TMAX) csh_cnt <= csh_cnt + 1;
            if (kill)                ab_flag <= 1'b1;
            else if (!cs_n_q)        ab_flag <= 1'b0;
            if (start_ok)            rise_cnt <= 0;
            else if (sclk_w && !sclk_d) rise_cnt <= rise_cnt + 1;
        end
    end

    a_r1_holdoff_gate: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_q) |-> $past(hold_exp) && !$past(pwr_down));

    a_r2_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        (state != ST_SHIFT) |-> !sclk_w);

    a_r5_min_phase: assert property (@(posedge clk) disable iff (rst)
        (sclk_w != sclk_d) && !$past(kill) |-> hold_cnt >= HALF_DIV);

    a_r6_r7_edge_count: assert property (@(posedge clk) disable iff (rst)
        done_q |-> rise_cnt == (mode_q ? CLK_BYTE : CLK_CONT));

    a_r8_done_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
        done_q |-> cs_n_q && !$past(cs_n_q) && !sclk_w);

    a_r10_cs_high_time: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_q) |-> csh_cnt >= CSH_CYC);

    a_r11_acq_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_q) && ab_flag |-> csh_cnt >= ACQ_CYC);

endmodule

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;

    localparam int KHZ     = 125000;
    localparam int HALF    = 13;
    localparam int HOLD    = 300;
    localparam int CONV_C  = (8500 * (KHZ / 1000) + 999) / 1000;
    localparam int CSH_C   = (500 * (KHZ / 1000) + 999) / 1000;
    localparam int ACQ_C   = (1500 * (KHZ / 1000) + 999) / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, byte_mode = 1'b0, abort_req = 1'b0, pwr_down = 1'b0;
    logic cs_n, sclk, done, frame_err;
    logic sdo = 1'b1;
    logic [11:0] result;

    adc_rd_ctrl #(
        .SYS_FREQ_KHZ(KHZ), .HALF_DIV(HALF), .HOLDOFF_CYC(HOLD)
    ) dut (
        .clk(clk), .rst(rst), .start_req(start_req), .byte_mode(byte_mode),
        .abort_req(abort_req), .pwr_down(pwr_down), .cs_n(cs_n), .sclk(sclk),
        .sdo_in(sdo), .done(done), .result(result), .frame_err(frame_err)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    // Converter model: framing bit at end of conversion, next bit on each falling clock.
    logic [15:0] m_seq = '0;
    int   m_dly = 30;
    int   m_cnt = 0, m_idx = 0;
    bit   m_eoc = 0;
    logic m_pcs = 1'b1, m_psclk = 1'b0;

    always @(negedge clk) begin
        if (cs_n) begin
            sdo = 1'b1; m_cnt = 0; m_idx = 0; m_eoc = 0;
        end else begin
            if (m_pcs) sdo = 1'b0;
            m_cnt++;
            if (!m_eoc && m_dly >= 0 && m_cnt == m_dly) begin
                sdo = 1'b1; m_eoc = 1;
            end
            if (m_psclk && !sclk) begin
                m_idx++;
                sdo = (m_idx < 16) ? m_seq[15 - m_idx] : 1'b0;
            end
        end
        m_pcs = cs_n; m_psclk = sclk;
    end

    // Port monitor.
    logic p_cs = 1'b1, p_sclk = 1'b0;
    int cs_fall_cyc = 0, cs_rise_cyc = 0, last_gap = 0, cs_falls = 0;
    int rises = 0, first_rise = -1, run_len = 0, done_cnt = 0;
    int hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0;
    bit seen_rise = 0;

    always @(negedge clk) begin
        if (p_cs && !cs_n) begin
            cs_fall_cyc = cyc; last_gap = cyc - cs_rise_cyc; cs_falls++;
            rises = 0; first_rise = -1; seen_rise = 0;
            hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
        end
        if (!p_cs && cs_n) cs_rise_cyc = cyc;
        if (sclk != p_sclk) begin
            if (p_sclk) begin
                if (run_len < hi_min) hi_min = run_len;
                if (run_len > hi_max) hi_max = run_len;
            end else if (seen_rise) begin
                if (run_len < lo_min) lo_min = run_len;
                if (run_len > lo_max) lo_max = run_len;
            end
            if (sclk) begin
                rises++;
                if (!seen_rise) first_rise = cyc - cs_fall_cyc;
                seen_rise = 1;
            end
            run_len = 1;
        end else begin
            run_len++;
        end
        if (done) done_cnt++;
        p_cs = cs_n; p_sclk = sclk;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(output bit ok);
        start_req = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            step();
            if (!cs_n) break;
        end
        start_req = 1'b0;
        ok = !cs_n;
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 5000; i++) begin
            step();
            if (done) begin got = 1; break; end
        end
    endtask

    task automatic t_reset_holdoff();
        rst = 1'b1;
        repeat (5) step();
        chk(cs_n == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1", "outputs in reset",
            {cs_n, sclk, done}, 3'b100);
        rst = 1'b0;
        start_req = 1'b1;
        begin
            int rel = cyc;
            int d;
            step();
            chk(cs_n == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1",
                "outputs after reset", {cs_n, sclk, done}, 3'b100);
            while (cs_n && (cyc - rel) < HOLD + 50) step();
            d = cs_fall_cyc - rel;
            chk(d >= HOLD - 1 && d <= HOLD + 4, "R1", "start delay after reset", d, HOLD);
        end
        start_req = 1'b0;
        begin
            bit got;
            m_seq = {1'b1, 12'h123, 3'b000};
            wait_done(got);
        end
    endtask

    task automatic t_read(input string req, input bit bm, input logic [11:0] data,
                          input logic [2:0] tail, input int dly);
        bit ok, got;
        int exp_r;
        m_seq = {1'b1, data, tail};
        m_dly = dly;
        byte_mode = bm;
        launch(ok);
        chk(ok, "R2", "cs_n low after start", cs_n, 0);
        chk(sclk == 1'b0, "R2", "sclk low at select", sclk, 0);
        wait_done(got);
        exp_r = bm ? 16 : 13;
        chk(got, req, "done seen", got, 1);
        chk(result == data, req, "result", result, data);
        chk(frame_err == 1'b0, "R9", "frame_err on good frame", frame_err, 0);
        chk(rises == exp_r, bm ? "R7" : "R6", "sclk rising edges", rises, exp_r);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R8", "cs_n high at done", {cs_n, sclk}, 2'b10);
        chk(first_rise <= dly + HALF + 6 && first_rise >= HALF, "R3",
            "first clock after data edge", first_rise, dly + HALF + 4);
        chk(hi_min == HALF && hi_max == HALF, "R5", "high phase", hi_min, HALF);
        chk(lo_min == HALF && lo_max == HALF, "R5", "low phase", lo_max, HALF);
        step();
        chk(done == 1'b0, "R8", "done single cycle", done, 0);
        chk(result == data, "R8", "result held", result, data);
    endtask

    task automatic t_timeout();
        bit ok, got;
        int exp_t = CONV_C + HALF + 1;
        m_seq = {1'b1, 12'h5A3, 3'b000};
        m_dly = -1;
        byte_mode = 1'b0;
        launch(ok);
        wait_done(got);
        chk(got, "R4", "done after timeout", got, 1);
        chk(first_rise >= CONV_C + HALF && first_rise <= CONV_C + HALF + 3, "R4",
            "first clock after timeout", first_rise, exp_t);
        chk(frame_err == 1'b1, "R9", "frame_err on missing framing bit", frame_err, 1);
        chk(result == 12'h5A3, "R9", "result with frame error", result, 12'h5A3);
        m_dly = 30;
    endtask

    task automatic t_gap();
        bit got;
        m_seq = {1'b1, 12'h6B7, 3'b000};
        m_dly = 30;
        byte_mode = 1'b0;
        start_req = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            step();
            if (!cs_n) break;
        end
        start_req = 1'b0;
        wait_done(got);
        start_req = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            step();
            if (!cs_n) break;
        end
        start_req = 1'b0;
        chk(last_gap >= CSH_C && last_gap <= CSH_C + 3, "R10", "select high time",
            last_gap, CSH_C + 1);
        wait_done(got);
        chk(got && result == 12'h6B7, "R10", "second back-to-back result", result, 12'h6B7);
    endtask

    task automatic t_abort();
        bit ok, got;
        int d0;
        m_seq = {1'b1, 12'h9E1, 3'b000};
        m_dly = 30;
        byte_mode = 1'b0;
        launch(ok);
        while (rises < 2 && !cs_n) step();
        d0 = done_cnt;
        abort_req = 1'b1;
        step();
        abort_req = 1'b0;
        chk(cs_n == 1'b1 && sclk == 1'b0, "R11", "abort releases lines", {cs_n, sclk}, 2'b10);
        launch(ok);
        chk(done_cnt == d0, "R11", "no done after abort", done_cnt, d0);
        chk(last_gap >= ACQ_C && last_gap <= ACQ_C + 3, "R11", "acquisition gap",
            last_gap, ACQ_C + 1);
        wait_done(got);
        chk(got && result == 12'h9E1, "R11", "read after abort", result, 12'h9E1);
    endtask

    task automatic t_pwrdown();
        bit ok, got;
        int f0, rel, d;
        pwr_down = 1'b1;
        start_req = 1'b1;
        f0 = cs_falls;
        repeat (400) step();
        chk(cs_falls == f0 && cs_n == 1'b1, "R12", "start refused in shutdown",
            cs_falls - f0, 0);
        pwr_down = 1'b0;
        rel = cyc;
        m_seq = {1'b1, 12'h0F0, 3'b000};
        m_dly = 30;
        while (cs_n && (cyc - rel) < HOLD + 50) step();
        d = cs_fall_cyc - rel;
        chk(d >= HOLD - 1 && d <= HOLD + 4, "R12", "hold-off after shutdown", d, HOLD);
        start_req = 1'b0;
        step();
        pwr_down = 1'b1;
        step();
        pwr_down = 1'b0;
        chk(cs_n == 1'b1 && sclk == 1'b0, "R12", "shutdown aborts read", cs_n, 1);
        rel = cyc;
        launch(ok);
        d = cs_fall_cyc - rel;
        chk(d >= HOLD - 1 && d <= HOLD + 4, "R12", "hold-off restarted", d, HOLD);
        wait_done(got);
        chk(got && result == 12'h0F0, "R12", "read after shutdown", result, 12'h0F0);
    endtask

    initial begin
        t_reset_holdoff();
        t_read("R6", 1'b0, 12'hA5C, 3'b000, 30);
        t_read("R6", 1'b0, 12'hFFF, 3'b000, 25);
        t_read("R6", 1'b0, 12'h000, 3'b000, 40);
        t_read("R7", 1'b1, 12'h3C9, 3'b111, 30);
        t_read("R7", 1'b1, 12'h801, 3'b000, 35);
        t_timeout();
        t_gap();
        t_abort();
        t_pwrdown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule